// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a small multi-cycle processor with an 8-bit accumulator, an 8-bit index register, a zero flag, a carry flag and a 16-bit program counter. It fetches instructions of one, two or three bytes over a single byte-wide synchronous memory port with a 16-bit address. It runs a compact instruction set made of loads, a store, index increment and decrement, add with carry, rotate right through carry, and absolute jumps, both unconditional and conditional.

The memory port is synchronous. When the core raises the read strobe, the byte at the presented address must appear on the read-data input in the following cycle. A write takes place in the cycle that the write enable is high. The core never reads and writes in the same cycle. An undefined opcode stops the core and raises a sticky halt output until reset.

Top module: `acc8_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator, the index register and both flags. In the first cycle after reset is released the core issues a read at address 0x0000.
- R2: An opcode byte of 0, 9, 10 or 27 makes a one-byte instruction. An opcode of 2 or 8 takes one immediate byte. An opcode of 1, 3, 16, 32, 34 or 36 takes a 16-bit address. Execution continues at the byte that follows the whole instruction.
- R3: Opcode 1 loads the accumulator from memory at the address. Opcode 2 loads the accumulator with the immediate byte. Opcode 3 writes the accumulator to memory at the address. Opcode 8 loads the index register with the immediate byte.
- R4: Opcode 9 adds one to the index register and opcode 10 subtracts one, both modulo 256. Each sets the zero flag to 1 when the new value is zero and clears it otherwise.
- R5: Opcode 16 adds the memory byte at the address and the carry flag to the accumulator. The low 8 bits go to the accumulator and the carry out of bit 7 goes to the carry flag. Both outputs are computed from the values held before the instruction, so a carry out never forces the result to zero.
- R6: Opcode 27 shifts the accumulator right by one bit. The old carry enters bit 7, and the old bit 0 becomes the new carry.
- R7: Opcode 32 jumps to the address. Opcode 34 jumps only when carry is 0, and opcode 36 jumps only when zero is 0. When a conditional jump is not taken, execution continues after the jump instruction.
- R8: Only opcodes 9 and 10 change the zero flag, and only opcodes 16 and 27 change the carry flag.
- R9: Any other opcode raises the halt output, which then stays high until reset. While it is high the core makes no further memory reads or writes.
- R10: The 16-bit address that follows an opcode is big-endian: the first byte after the opcode is bits 15:8.
- R11: The read strobe and the write enable are never high in the same cycle. Read data is taken in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Write data (the accumulator) |
| memRdata | input | 8 | Read data, valid the cycle after memRe |
| memWe | output | 1 | Write enable |
| memRe | output | 1 | Read strobe |
| halt | output | 1 | Sticky illegal-opcode halt |

## Verification
The flag state is the hardest part to reach from the ports. Nothing reads the flags or the index register directly. The carry shows up only when a rotate moves it into the accumulator and a store then writes it out. The zero flag shows up only when a conditional jump skips a store or does not. The directed programs chain these steps to make each flag visible, including an add whose result wraps to exactly zero while carry is set. Random straight-line programs with forward jumps are run against an instruction-level model in the bench. The bench compares the data memory and the address at which the core halts.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam logic [7:0] OP_NOP  = 8'd0;
  localparam logic [7:0] OP_LDA  = 8'd1;
  localparam logic [7:0] OP_LDC  = 8'd2;
  localparam logic [7:0] OP_STA  = 8'd3;
  localparam logic [7:0] OP_LDX  = 8'd8;
  localparam logic [7:0] OP_INCX = 8'd9;
  localparam logic [7:0] OP_DECX = 8'd10;
  localparam logic [7:0] OP_ADD  = 8'd16;
  localparam logic [7:0] OP_ROR  = 8'd27;
  localparam logic [7:0] OP_JMP  = 8'd32;
  localparam logic [7:0] OP_JNC  = 8'd34;
  localparam logic [7:0] OP_JNZ  = 8'd36;

  typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_ADD, ACC_ROR} accOp_e;
  typedef enum logic [1:0] {X_HOLD, X_LOAD, X_INC, X_DEC} xOp_e;

  typedef struct packed {
    logic   pcInc;
    logic   pcLoad;
    logic   hiLoad;
    logic   absAddr;
    accOp_e accOp;
    xOp_e   xOp;
  } strobe_t;
endpackage

// File: rtl/acc8_dpath.sv
module acc8_dpath
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DW-1:0]     memRdata,
  output logic [2*DW-1:0]   memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              zFlag,
  output logic              cFlag
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] pc;
  logic [DW-1:0] acc, xReg, hiByte;
  logic [AW-1:0] target;
  logic [DW:0]   sumWide;
  logic [DW-1:0] xInc, xDec;

  assign target   = {hiByte, memRdata};
  assign memAddr  = stb.absAddr ? target : pc;
  assign memWdata = acc;
  assign sumWide  = {1'b0, acc} + {1'b0, memRdata} + {{DW{1'b0}}, cFlag};
  assign xInc     = xReg + {{(DW-1){1'b0}}, 1'b1};
  assign xDec     = xReg - {{(DW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      acc    <= '0;
      xReg   <= '0;
      hiByte <= '0;
      zFlag  <= 1'b0;
      cFlag  <= 1'b0;
    end else begin
      if (stb.pcLoad)     pc <= target;
      else if (stb.pcInc) pc <= pc + {{(AW-1){1'b0}}, 1'b1};
      if (stb.hiLoad) hiByte <= memRdata;
      case (stb.accOp)
        ACC_LOAD: acc <= memRdata;
        ACC_ADD: begin
          acc   <= sumWide[DW-1:0];
          cFlag <= sumWide[DW];
        end
        ACC_ROR: begin
          acc   <= {cFlag, acc[DW-1:1]};
          cFlag <= acc[0];
        end
        default: ;
      endcase
      case (stb.xOp)
        X_LOAD: xReg <= memRdata;
        X_INC: begin
          xReg  <= xInc;
          zFlag <= (xInc == '0);
        end
        X_DEC: begin
          xReg  <= xDec;
          zFlag <= (xDec == '0);
        end
        default: ;
      endcase
    end
  end

  // R8: carry only moves on add or rotate
  p_carry_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.accOp == ACC_HOLD || stb.accOp == ACC_LOAD) |=> $stable(cFlag));
  // R8: zero only moves on index step
  p_zero_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.xOp == X_HOLD || stb.xOp == X_LOAD) |=> $stable(zFlag));
  // R6: rotate passes through carry
  p_ror_r6: assert property (@(posedge clk) disable iff (rst)
    (stb.accOp == ACC_ROR) |=> (acc[DW-1] == $past(cFlag)) && (cFlag == $past(acc[0])));
  // R4: zero flag matches new index value
  p_zero_track_r4: assert property (@(posedge clk) disable iff (rst)
    (stb.xOp == X_INC || stb.xOp == X_DEC) |=> (zFlag == (xReg == '0)));
endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] memRdata,
  input  logic          zFlag,
  input  logic          cFlag,
  output strobe_t       stb,
  output logic          memRe,
  output logic          memWe,
  output logic          halt
);
  typedef enum logic [2:0] {S_FETCH, S_OP, S_IMM, S_HI, S_LO, S_DATA, S_HALT} state_e;

  state_e state, nextState;
  logic [DW-1:0] ir;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      ir    <= '0;
    end else begin
      state <= nextState;
      if (state == S_OP) ir <= memRdata;
    end
  end

  always_comb begin
    stb       = '0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      S_FETCH: begin
        memRe     = 1'b1;
        stb.pcInc = 1'b1;
        nextState = S_OP;
      end
      S_OP: begin
        case (memRdata)
          OP_NOP:  nextState = S_FETCH;
          OP_INCX: begin stb.xOp = X_INC; nextState = S_FETCH; end
          OP_DECX: begin stb.xOp = X_DEC; nextState = S_FETCH; end
          OP_ROR:  begin stb.accOp = ACC_ROR; nextState = S_FETCH; end
          OP_LDC, OP_LDX: begin
            memRe = 1'b1; stb.pcInc = 1'b1; nextState = S_IMM;
          end
          OP_LDA, OP_STA, OP_ADD, OP_JMP, OP_JNC, OP_JNZ: begin
            memRe = 1'b1; stb.pcInc = 1'b1; nextState = S_HI;
          end
          default: nextState = S_HALT;
        endcase
      end
      S_IMM: begin
        if (ir == OP_LDC) stb.accOp = ACC_LOAD;
        else              stb.xOp   = X_LOAD;
        nextState = S_FETCH;
      end
      S_HI: begin
        stb.hiLoad = 1'b1;
        memRe      = 1'b1;
        stb.pcInc  = 1'b1;
        nextState  = S_LO;
      end
      S_LO: begin
        nextState = S_FETCH;
        case (ir)
          OP_JMP: stb.pcLoad = 1'b1;
          OP_JNC: stb.pcLoad = !cFlag;
          OP_JNZ: stb.pcLoad = !zFlag;
          OP_STA: begin stb.absAddr = 1'b1; memWe = 1'b1; end
          default: begin
            stb.absAddr = 1'b1; memRe = 1'b1; nextState = S_DATA;
          end
        endcase
      end
      S_DATA: begin
        stb.accOp = (ir == OP_ADD) ? ACC_ADD : ACC_LOAD;
        nextState = S_FETCH;
      end
      default: nextState = S_HALT;
    endcase
  end

  assign halt = (state == S_HALT);

  // R9: halt is sticky
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  // R9: no memory traffic while halted
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halt |-> !memRe && !memWe);
  // R11: one access per cycle
  p_single_access_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRe, memWe}));
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [2*DW-1:0]   memAddr,
  output logic [DW-1:0]     memWdata,
  input  logic [DW-1:0]     memRdata,
  output logic              memWe,
  output logic              memRe,
  output logic              halt
);
  strobe_t stb;
  logic zFlag, cFlag;

  acc8_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .memRdata(memRdata), .zFlag(zFlag), .cFlag(cFlag),
    .stb(stb), .memRe(memRe), .memWe(memWe), .halt(halt)
  );

  acc8_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .zFlag(zFlag), .cFlag(cFlag)
  );

  // R1: first access after reset is a read at zero
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> memRe && (memAddr == '0) && !halt);
endmodule

// File: tb/acc8_core_bench.sv
module acc8_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic memWe, memRe, halt;

  always #10 clk = ~clk;

  acc8_core u_acc8_core (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .memRe(memRe), .halt(halt)
  );

  logic [7:0] mem    [0:4095];
  logic [7:0] refMem [0:4095];
  logic [15:0] lastRead;
  logic [15:0] ep;
  int checks = 0;
  int errors = 0;
  int bothCnt = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (memWe) mem[memAddr[11:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[11:0]];
    if (!rst && memRe) lastRead <= memAddr;
  end

  always @(negedge clk) if (!rst && memWe && memRe) bothCnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    mem[ep[11:0]] = b;
    ep = ep + 16'd1;
  endtask
  task automatic i1(input logic [7:0] op); emit(op); endtask
  task automatic i2(input logic [7:0] op, input logic [7:0] v); emit(op); emit(v); endtask
  task automatic i3(input logic [7:0] op, input logic [15:0] a);
    emit(op); emit(a[15:8]); emit(a[7:0]);
  endtask
  task automatic jfwd(input logic [7:0] op, output logic [15:0] loc);
    loc = ep + 16'd1;
    i3(op, 16'h0000);
  endtask
  task automatic patch(input logic [15:0] loc, input logic [15:0] tgt);
    mem[loc[11:0]] = tgt[15:8];
    mem[loc[11:0] + 12'd1] = tgt[7:0];
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    ep = 16'h0000;
  endtask

  // instruction-level model of the requirements
  task automatic iss(output logic [15:0] haltPc);
    logic [15:0] p, q1, q2, ea;
    logic [7:0] a, x, op;
    logic z, c;
    logic [8:0] s;
    p = 0; a = 0; x = 0; z = 0; c = 0;
    haltPc = 16'hFFFF;
    for (int n = 0; n < 3000; n++) begin
      q1 = p + 16'd1; q2 = p + 16'd2;
      op = refMem[p[11:0]];
      ea = {refMem[q1[11:0]], refMem[q2[11:0]]};
      case (op)
        8'd0:  p = p + 1;
        8'd1:  begin a = refMem[ea[11:0]]; p = p + 3; end
        8'd2:  begin a = refMem[q1[11:0]]; p = p + 2; end
        8'd3:  begin refMem[ea[11:0]] = a; p = p + 3; end
        8'd8:  begin x = refMem[q1[11:0]]; p = p + 2; end
        8'd9:  begin x = x + 1; z = (x == 0); p = p + 1; end
        8'd10: begin x = x - 1; z = (x == 0); p = p + 1; end
        8'd16: begin s = {1'b0, a} + {1'b0, refMem[ea[11:0]]} + {8'd0, c};
                     a = s[7:0]; c = s[8]; p = p + 3; end
        8'd27: begin {a, c} = {c, a}; p = p + 1; end
        8'd32: p = ea;
        8'd34: p = c ? p + 3 : ea;
        8'd36: p = z ? p + 3 : ea;
        default: begin haltPc = p; return; end
      endcase
    end
  endtask

  task automatic runProgram(input string tag, input bit resetCheck);
    logic [15:0] expHalt;
    int bad;
    for (int i = 0; i < 4096; i++) refMem[i] = mem[i];
    iss(expHalt);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    if (resetCheck) begin
      check("R1 reset read strobe", {15'd0, memRe}, 16'd1);
      check("R1 reset address", memAddr, 16'h0000);
      check("R1 reset halt low", {15'd0, halt}, 16'd0);
    end
    for (int k = 0; k < 5000 && !halt; k++) @(negedge clk);
    check({tag, " halt address"}, lastRead, expHalt);
    bad = 0;
    for (int i = 12'h800; i < 12'h900; i++) if (mem[i] !== refMem[i]) bad++;
    check({tag, " data region mismatches"}, bad[15:0], 16'd0);
  endtask

  task automatic genRandom();
    logic [15:0] starts [0:16];
    logic [15:0] locs [0:15];
    int tgts [0:15];
    int np;
    int n;
    logic [15:0] da;
    for (int i = 0; i < 4096; i++) mem[i] = (i >= 12'h800) ? 8'($urandom) : 8'hFF;
    ep = 0; np = 0; n = 14;
    for (int i = 0; i < n; i++) begin
      starts[i] = ep;
      da = 16'h0800 + 16'($urandom % 32);
      case ($urandom % 12)
        0: i1(8'd0);
        1: i2(8'd2, 8'($urandom));
        2: i2(8'd8, 8'($urandom % 3) + 8'hFE);
        3: i1(8'd9);
        4: i1(8'd10);
        5, 6: i3(8'd16, da);
        7: i1(8'd27);
        8: i3(8'd3, da);
        9: i3(8'd1, da);
        default: begin
          jfwd((($urandom % 3) == 0) ? 8'd32 : ((($urandom % 2) == 0) ? 8'd34 : 8'd36), locs[np]);
          tgts[np] = i + 1 + int'($urandom % 3);
          if (tgts[np] > n) tgts[np] = n;
          np++;
        end
      endcase
    end
    starts[n] = ep;
    i3(8'd3, 16'h08F0);
    i1(8'd27);
    i3(8'd3, 16'h08F1);
    i1(8'hFF);
    for (int j = 0; j < np; j++) patch(locs[j], starts[tgts[j]]);
  endtask

  initial begin
    logic [15:0] l1, l2, l3, l4;
    void'($urandom(32'd1357));

    // R1: state after reset observed through stores
    clearMem();
    i3(8'd3, 16'h0800); i1(8'd27); i3(8'd3, 16'h0801); i1(8'hFF);
    mem[12'h800] = 8'hAA; mem[12'h801] = 8'hBB;
    runProgram("R1", 1'b1);
    check("R1 accumulator zero", {8'd0, mem[12'h800]}, 16'h0000);
    check("R1 carry zero", {8'd0, mem[12'h801]}, 16'h0000);

    // R3 R10: loads and store, big-endian address
    clearMem();
    mem[12'h234] = 8'h5A; mem[12'h402] = 8'hA5;
    i3(8'd1, 16'h0234); i3(8'd3, 16'h0820); i2(8'd2, 8'h77); i3(8'd3, 16'h0821); i1(8'hFF);
    runProgram("R3", 1'b0);
    check("R10 big-endian load", {8'd0, mem[12'h820]}, 16'h005A);
    check("R3 immediate store", {8'd0, mem[12'h821]}, 16'h0077);

    // R5: add with carry, including wrap to zero with carry set
    clearMem();
    mem[12'h900] = 8'h20;
    i2(8'd2, 8'hF0); i3(8'd16, 16'h0900); i3(8'd3, 16'h0800);
    i2(8'd2, 8'hDF); i3(8'd16, 16'h0900); i3(8'd3, 16'h0801);
    i1(8'd27); i3(8'd3, 16'h0802);
    i2(8'd2, 8'h01); i3(8'd16, 16'h0900); i3(8'd3, 16'h0803); i1(8'hFF);
    runProgram("R5", 1'b0);
    check("R5 sum with carry out", {8'd0, mem[12'h800]}, 16'h0010);
    check("R5 carry-in wraps to zero", {8'd0, mem[12'h801]}, 16'h0000);
    check("R5 carry out kept", {8'd0, mem[12'h802]}, 16'h0080);
    check("R5 carry cleared", {8'd0, mem[12'h803]}, 16'h0021);

    // R6: rotate through carry
    clearMem();
    i2(8'd2, 8'h03); i1(8'd27); i3(8'd3, 16'h0810); i1(8'd27); i3(8'd3, 16'h0811);
    i1(8'd27); i3(8'd3, 16'h0812); i1(8'hFF);
    runProgram("R6", 1'b0);
    check("R6 rotate bit0 out", {8'd0, mem[12'h810]}, 16'h0001);
    check("R6 carry into bit7", {8'd0, mem[12'h811]}, 16'h0080);
    check("R6 rotate chain", {8'd0, mem[12'h812]}, 16'h00C0);

    // R4 R7: index steps, zero flag and jumps
    clearMem();
    i2(8'd8, 8'h01); i1(8'd10); jfwd(8'd36, l1); i2(8'd2, 8'h11); i3(8'd3, 16'h0830);
    patch(l1, ep);
    i2(8'd8, 8'hFF); i1(8'd9); jfwd(8'd36, l2); i2(8'd2, 8'h22); i3(8'd3, 16'h0831);
    patch(l2, ep);
    i2(8'd8, 8'h05); i1(8'd9); jfwd(8'd36, l3); i2(8'd2, 8'h33); i3(8'd3, 16'h0832);
    patch(l3, ep);
    jfwd(8'd34, l4); i2(8'd2, 8'h44); i3(8'd3, 16'h0833);
    patch(l4, ep);
    jfwd(8'd32, l1); i2(8'd2, 8'h55); i3(8'd3, 16'h0834);
    patch(l1, ep);
    i2(8'd2, 8'h66); i3(8'd3, 16'h0835); i1(8'hFF);
    runProgram("R7", 1'b0);
    check("R4 decrement to zero", {8'd0, mem[12'h830]}, 16'h0011);
    check("R4 increment wraps to zero", {8'd0, mem[12'h831]}, 16'h0022);
    check("R7 jnz taken", {8'd0, mem[12'h832]}, 16'h0000);
    check("R7 jnc taken", {8'd0, mem[12'h833]}, 16'h0000);
    check("R7 jmp", {8'd0, mem[12'h834]}, 16'h0000);
    check("R7 path after jumps", {8'd0, mem[12'h835]}, 16'h0066);

    // R8: loads, stores and jumps keep the flags
    clearMem();
    i2(8'd2, 8'h01); i1(8'd27); i2(8'd2, 8'h00); i2(8'd8, 8'h00);
    i3(8'd3, 16'h0840); i3(8'd1, 16'h0840); i3(8'd32, ep + 16'd3);
    i1(8'd27); i3(8'd3, 16'h0841);
    i2(8'd8, 8'h01); i1(8'd10); i2(8'd8, 8'h07); i2(8'd2, 8'h09);
    jfwd(8'd36, l1); i2(8'd2, 8'h5C); i3(8'd3, 16'h0842);
    patch(l1, ep); i1(8'hFF);
    runProgram("R8", 1'b0);
    check("R8 carry kept over loads", {8'd0, mem[12'h841]}, 16'h0080);
    check("R8 zero kept over loads", {8'd0, mem[12'h842]}, 16'h005C);

    // R9: illegal opcode halts for good
    clearMem();
    i2(8'd2, 8'h3C); i3(8'd3, 16'h0850); i1(8'h05); i2(8'd2, 8'h99); i3(8'd3, 16'h0851);
    i1(8'hFF);
    runProgram("R9", 1'b0);
    check("R9 halt at illegal opcode", lastRead, 16'h0005);
    check("R9 stops before next store", {8'd0, mem[12'h851]}, 16'h0000);
    begin
      int traffic = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (memRe || memWe) traffic++;
        if (!halt) traffic++;
      end
      check("R9 halt sticky and quiet", traffic[15:0], 16'd0);
    end

    // R2: random programs against the model
    for (int t = 0; t < 30; t++) begin
      genRandom();
      runProgram("R2", 1'b0);
    end

    check("R11 read and write never together", bothCnt[15:0], 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule